// File: doc/BRIEF.md
# Banked Single-Bit Memory Operation Unit

This block carries out one single-bit operation on a nibble-wide data memory. Each request names a bit directly: an 8-bit operand address and a 2-bit bit index. The unit turns the operand into a 12-bit physical address by putting a 4-bit bank number above it. Two kinds of operation are supported:

- **Set and clear** are done as a read-modify-write through a synchronous memory port.
- **The two bit tests** read the word and raise a one-cycle skip decision that the surrounding sequencer can act on.

Bank resolution depends on a bank-enable flag. With the flag clear, the top bit of the operand chooses between the lowest bank and the highest bank. One flat 8-bit operand space therefore covers the bottom of data RAM and the peripheral window at the top of the map. With the flag set, a 4-bit bank-select value chooses the bank for every operand. The unit accepts one request at a time through a start/busy/done handshake. It captures everything it needs, the bank included, when it accepts the request.

Top module: `bitop_unit`

## Requirements
- R1: With `bank_en` = 0 and an operand in 00h..7Fh, the physical address bits 11:8 are 0.
- R2: With `bank_en` = 0 and an operand in 80h..FFh, the physical address bits 11:8 are 15, so addresses F80h..FFFh are reachable.
- R3: With `bank_en` = 1, bits 11:8 of the physical address equal `bank_sel` for every operand value.
- R4: `mem_addr` is {bank, operand}: bank in bits 11:8 and the 8-bit operand in bits 7:0.
- R5: Operation code 0 (set) writes the word back with the indexed bit forced to 1 and the other three bits unchanged.
- R6: Operation code 1 (clear) writes the word back with the indexed bit forced to 0 and the other three bits unchanged.
- R7: Operation code 2 (skip-if-one) raises `skip` together with `done` exactly when the indexed bit reads 1.
- R8: Operation code 3 (skip-if-zero) raises `skip` together with `done` exactly when the indexed bit reads 0.
- R9: The two test operations never assert `mem_wr` and leave memory unchanged.
- R10: Handshake timing:
  - A `start` seen while idle is accepted at that clock edge.
  - `mem_rd` is high for the next cycle, and memory returns the word one cycle after the read.
  - `done` is high for exactly one cycle, two cycles after acceptance. Any write happens in that same cycle, to the address that was read.
  - `busy` covers the read cycle and the done cycle.
  - A `start` that arrives while busy is ignored.
- R11: The bank is captured at acceptance. Changes to `bank_sel` or `bank_en` during an operation do not move its address.
- R12: After reset, `busy`, `done`, `skip`, `mem_rd` and `mem_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | 0 set, 1 clear, 2 skip-if-one, 3 skip-if-zero |
| operand | input | 8 | Direct operand address |
| bit_idx | input | 2 | Bit within the nibble (0..3) |
| bank_en | input | 1 | 1: bank from `bank_sel`; 0: bank from operand bit 7 |
| bank_sel | input | 4 | Bank-select register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Skip decision, valid with `done` |
| mem_addr | output | 12 | Physical memory address |
| mem_rd | output | 1 | Read request (data one cycle later) |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data from memory |

## Verification
The embedded properties watch several things on every cycle:
- bank resolution and address composition for each accepted request;
- that the address holds steady while the unit is busy;
- that a write differs from the word read back in at most one bit;
- the read-then-done cadence, with done pulses one cycle wide;
- that a skip never appears without done or alongside a write.

Three behaviours depend on particular values and ordering, so only the bench scenarios show them:
- which bit is changed and to what value, and whether the skip polarity is right for each bit index;
- that memory really stays intact after a test;
- that a start raised during a busy period launches nothing.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OPER_W = 8;
  localparam int BANK_W = 4;
  localparam int DATA_W = 4;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int ADDR_W = BANK_W + OPER_W;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_CLR = 2'd1,
    OP_SKT = 2'd2,
    OP_SKF = 2'd3
  } bitop_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;

  // Writing operations modify memory; the others only observe it.
  function automatic logic op_writes(bitop_e o);
    return (o == OP_SET) || (o == OP_CLR);
  endfunction

  // Target value: the value forced by a write, or the value that triggers a skip.
  function automatic logic op_level(bitop_e o);
    return (o == OP_SET) || (o == OP_SKT);
  endfunction

  // Bank choice: explicit select, or forced by the operand's top bit.
  function automatic logic [BANK_W-1:0] pick_bank(
    input logic              en,
    input logic [BANK_W-1:0] sel,
    input logic              top_bit,
    input logic [BANK_W-1:0] low_bank,
    input logic [BANK_W-1:0] high_bank
  );
    if (en) return sel;
    return top_bit ? high_bank : low_bank;
  endfunction

endpackage

// File: rtl/bitop_bank.sv
module bitop_bank
  import bitop_pkg::*;
#(
  parameter int                 OW        = OPER_W,
  parameter int                 BW        = BANK_W,
  parameter logic [BANK_W-1:0]  LOW_BANK  = '0,
  parameter logic [BANK_W-1:0]  HIGH_BANK = '1
) (
  input  logic          bank_en,
  input  logic [BW-1:0] bank_sel,
  input  logic [OW-1:0] operand,
  output logic [BW+OW-1:0] phys_addr
);
  logic [BW-1:0] bank_w;

  always_comb begin
    bank_w    = pick_bank(bank_en, bank_sel, operand[OW-1], LOW_BANK, HIGH_BANK);
    phys_addr = {bank_w, operand};
  end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
  import bitop_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic [DW-1:0] rdata,
  input  logic [IW-1:0] idx,
  input  logic          level,
  output logic [DW-1:0] wdata,
  output logic          hit
);
  logic [DW-1:0] sel_onehot;

  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign sel_onehot[g] = (idx == IW'(g));
    assign wdata[g]      = sel_onehot[g] ? level : rdata[g];
  end

  assign hit = ((rdata & sel_onehot) != '0) == level;
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic in_read,
  output logic in_finish,
  output logic busy
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_READ;
      ST_READ:   state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept    = (state_q == ST_IDLE) && start;
  assign in_read   = (state_q == ST_READ);
  assign in_finish = (state_q == ST_FINISH);
  assign busy      = in_read || in_finish;

  // R10: a read cycle is always followed by the completion cycle
  a_r10_read_then_finish: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |=> in_finish);
  // R10: completion lasts one cycle
  a_r10_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_finish |=> !in_finish);
  // R10: an acceptance always leads into a read
  a_r10_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> in_read);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [OPER_W-1:0]   operand,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic                bank_en,
  input  logic [BANK_W-1:0]   bank_sel,
  output logic                busy,
  output logic                done,
  output logic                skip,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  logic              accept, in_read, in_finish;
  logic [ADDR_W-1:0] phys_addr;
  logic [ADDR_W-1:0] addr_q;
  bitop_e            op_q;
  logic [IDX_W-1:0]  idx_q;
  logic              hit;
  logic              level;
  logic [DATA_W-1:0] new_word;

  bitop_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .in_read   (in_read),
    .in_finish (in_finish),
    .busy      (busy)
  );

  bitop_bank #(
    .OW (OPER_W),
    .BW (BANK_W)
  ) u_bank (
    .bank_en   (bank_en),
    .bank_sel  (bank_sel),
    .operand   (operand),
    .phys_addr (phys_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      op_q   <= OP_SET;
      idx_q  <= '0;
    end else if (accept) begin
      addr_q <= phys_addr;
      op_q   <= bitop_e'(op);
      idx_q  <= bit_idx;
    end
  end

  assign level = op_level(op_q);

  bitop_modify #(
    .DW (DATA_W),
    .IW (IDX_W)
  ) u_modify (
    .rdata (mem_rdata),
    .idx   (idx_q),
    .level (level),
    .wdata (new_word),
    .hit   (hit)
  );

  assign mem_addr  = addr_q;
  assign mem_rd    = in_read;
  assign mem_wr    = in_finish && op_writes(op_q);
  assign mem_wdata = new_word;
  assign done      = in_finish;
  assign skip      = in_finish && !op_writes(op_q) && hit;

  // R4: the low byte of the address is the operand that was accepted
  a_r4_operand_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_addr[OPER_W-1:0] == $past(operand));
  // R1: low operands without bank enable land in bank 0
  a_r1_low_bank: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !bank_en && !operand[OPER_W-1] |=> mem_addr[ADDR_W-1:OPER_W] == '0);
  // R2: high operands without bank enable land in the top bank
  a_r2_high_bank: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !bank_en && operand[OPER_W-1] |=> mem_addr[ADDR_W-1:OPER_W] == '1);
  // R3: bank enable takes the bank from the select register
  a_r3_selected_bank: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bank_en |=> mem_addr[ADDR_W-1:OPER_W] == $past(bank_sel));
  // R11: address held for the whole operation
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));
  // R5: a write-back differs from the word read in at most one bit
  a_r5_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $countones(mem_wdata ^ mem_rdata) <= 1);
  // R7: a skip only comes with completion
  a_r7_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done);
  // R9: a skip never coincides with a write
  a_r9_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !mem_wr);
  // R10: writes happen only in the completion cycle
  a_r10_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> done);
endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  operand = 8'd0;
  logic [1:0]  bit_idx = 2'd0;
  logic        bank_en = 1'b0;
  logic [3:0]  bank_sel = 4'd0;
  logic        busy, done, skip, mem_rd, mem_wr;
  logic [11:0] mem_addr;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata = 4'd0;

  always #5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .bit_idx(bit_idx), .bank_en(bank_en), .bank_sel(bank_sel),
    .busy(busy), .done(done), .skip(skip), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [3:0] mem    [0:4095];
  logic [3:0] shadow [0:4095];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_seen = 0;
  int rd_expect = 0;
  bit prev_done = 1'b0;

  typedef struct {
    string       req;
    bit          wr;
    logic [11:0] addr;
    logic [3:0]  wdata;
    bit          skip;
    int          issue;
  } item_t;
  item_t sb[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input bit ok, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // Monitor: samples between edges and compares completions against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_seen++;
      if (done && prev_done) check("R10 done width", 1'b0, 1, 0);
      if (done) begin
        if (sb.size() == 0) check("R10 unexpected done", 1'b0, 1, 0);
        else begin
          item_t it;
          it = sb.pop_front();
          check({it.req, " addr"}, mem_addr == it.addr, mem_addr, it.addr);
          check({it.req, " write strobe"}, mem_wr == it.wr, mem_wr, it.wr);
          check({it.req, " skip"}, skip == it.skip, skip, it.skip);
          check("R10 done latency", cyc == it.issue + 2, cyc - it.issue, 2);
          if (it.wr) check({it.req, " wdata"}, mem_wdata == it.wdata, mem_wdata, it.wdata);
        end
      end
      prev_done = done;
    end
  end

  // Driver: issues one request and pushes the expected outcome
  task automatic do_op(input string req, input logic [1:0] o, input logic [7:0] opnd,
                       input logic [1:0] idx, input logic en, input logic [3:0] sel,
                       input bit disturb);
    item_t it;
    logic [3:0]  bank;
    logic [3:0]  word;
    bank = en ? sel : (opnd[7] ? 4'hF : 4'h0);
    it.req  = req;
    it.addr = {bank, opnd};
    word    = shadow[it.addr];
    it.wr   = (o == 2'd0) || (o == 2'd1);
    it.wdata = word;
    it.wdata[idx] = (o == 2'd0);
    it.skip = (o == 2'd2) ? word[idx] : (o == 2'd3) ? !word[idx] : 1'b0;
    if (it.wr) shadow[it.addr] = it.wdata;
    @(negedge clk);
    it.issue = cyc;
    sb.push_back(it);
    rd_expect++;
    op = o; operand = opnd; bit_idx = idx; bank_en = en; bank_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      bank_sel = ~sel; bank_en = ~en; operand = ~opnd; op = 2'd0; start = 1'b1;
    end
    while (sb.size() != 0) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]    = 4'(i) ^ 4'(i >> 4) ^ 4'(i >> 8);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", busy == 0, busy, 0);
    check("R12 done", done == 0, done, 0);
    check("R12 skip", skip == 0, skip, 0);
    check("R12 rd/wr", {mem_rd, mem_wr} == 0, {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle after release", busy == 0, busy, 0);

    do_op("R1 R5 set low bank",       2'd0, 8'h3F, 2'd1, 1'b0, 4'h9, 0);
    do_op("R2 R6 clear high bank",    2'd1, 8'h87, 2'd2, 1'b0, 4'h3, 0);
    do_op("R2 R8 skip-if-zero high",  2'd3, 8'hA7, 2'd0, 1'b0, 4'h0, 0);
    do_op("R3 R4 set selected bank",  2'd0, 8'h12, 2'd3, 1'b1, 4'h6, 0);
    do_op("R3 R6 clear bank 5 high",  2'd1, 8'hF0, 2'd0, 1'b1, 4'h5, 0);
    do_op("R5 set bit 0",             2'd0, 8'h00, 2'd0, 1'b0, 4'h0, 0);
    do_op("R5 set bit 2",             2'd0, 8'h7F, 2'd2, 1'b0, 4'h0, 0);
    do_op("R7 skip-if-one after set", 2'd2, 8'h3F, 2'd1, 1'b0, 4'h0, 0);
    do_op("R8 skip-if-zero after clr",2'd3, 8'h87, 2'd2, 1'b0, 4'h0, 0);
    do_op("R7 skip-if-one on zero",   2'd2, 8'h87, 2'd2, 1'b0, 4'h0, 0);
    do_op("R8 skip-if-zero on one",   2'd3, 8'h3F, 2'd1, 1'b0, 4'h0, 0);
    do_op("R7 skip-if-one bit 3",     2'd2, 8'hFF, 2'd3, 1'b1, 4'hA, 0);
    // R9: tests leave the word untouched
    do_op("R9 test does not write",   2'd3, 8'h55, 2'd1, 1'b1, 4'h2, 0);
    check("R9 memory intact", mem[12'h255] == shadow[12'h255], mem[12'h255], shadow[12'h255]);
    // R11 and R10: disturb bank and raise start while busy
    do_op("R11 bank captured",        2'd0, 8'h44, 2'd3, 1'b1, 4'h7, 1);
    repeat (4) @(negedge clk);
    check("R10 start while busy ignored", rd_seen == rd_expect, rd_seen, rd_expect);
    check("R10 idle afterwards", busy == 0, busy, 0);
    check("R11 word at captured bank", mem[12'h744] == shadow[12'h744], mem[12'h744], shadow[12'h744]);
    do_op("R11 low bank disturbed",   2'd1, 8'h10, 2'd0, 1'b0, 4'hC, 1);
    repeat (4) @(negedge clk);
    check("R10 rd count", rd_seen == rd_expect, rd_seen, rd_expect);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule